// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The block follows a linked set of eight-word transmit descriptors in memory for an Ethernet transmit path. After a start pulse it latches a base address and reads descriptors through a single-word memory read/write port. It always reads word 0 first. If the descriptor is owned by the engine, it reads the remaining three control words. It then hands each non-empty buffer (address plus byte count) to a downstream data mover over a request/acknowledge handshake. Payload movement is not part of this block.

When the buffers are done, the engine writes the timestamp pair returned by the mover into words 6 and 7. It then writes word 0 back with the ownership flag cleared, which returns the descriptor to software. The next descriptor address comes from one of three places: the base address (end of ring), the link word (chain mode), or the current address plus 32 bytes.

A descriptor not owned by the engine puts it into a suspended state. It leaves that state only on a poll-demand pulse, and then re-reads the same descriptor. The memory and mover acknowledges are single-cycle pulses, each answering the request that is currently held.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset, mem_req, mv_req, suspended and irq are all low and the engine waits for a start pulse.
- R2: A start pulse latches base_addr. The first read is word 0 at that address, and word k of a descriptor is read at descriptor address + 4k.
- R3: If word 0 bit 31 (ownership) reads 0, no buffer is issued and suspended goes high. While suspended, no memory or mover request is made. A poll_demand pulse makes the engine re-read word 0 at the same address.
- R4: Buffer 1 (address in word 2, byte count in word 1 bits 12:0) is issued before buffer 2 (address in word 3, byte count in word 1 bits 28:16). A buffer with a zero count is not issued.
- R5: When word 0 bit 20 (chain) is set, buffer 2 is never issued, and the next descriptor address is word 3.
- R6: With word 0 bit 21 (end of ring) set, the next descriptor address is the latched base, and this takes priority over chain mode. With neither bit 21 nor bit 20 set, the next descriptor address is the current address + 32.
- R7: Write-back order is word 6 (timestamp bits 31:0) at +24, then word 7 (bits 63:32) at +28, then word 0 at +0. The word 0 value has bit 31 = 0, bits 30:16 as fetched, and bits 15:0 = OR of mv_stat over the issued buffers. The timestamp is mv_ts from the last acknowledged buffer, or zero when no buffer was issued.
- R8: irq is a one-cycle pulse in the cycle after the word 0 write-back acknowledge, raised only when word 0 bit 29 (last segment) and bit 30 (interrupt request) are both set.
- R9: A poll_demand pulse in the same cycle as the acknowledge that returns a non-owned word 0 is honoured: the engine re-reads word 0 immediately and does not enter the suspended state.
- R10: mem_req and mv_req stay high with stable address, direction and length until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: latch base_addr and begin walking (idle only) |
| base_addr | input | 32 | Address of the first descriptor |
| poll_demand | input | 1 | Pulse: retry the current descriptor |
| suspended | output | 1 | High while waiting for ownership |
| irq | output | 1 | Completion interrupt pulse |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Buffer transfer request |
| mv_addr | output | 32 | Buffer address |
| mv_len | output | 13 | Buffer byte count |
| mv_ack | input | 1 | One-cycle transfer completion |
| mv_stat | input | 16 | Transfer status bits, valid with mv_ack |
| mv_ts | input | 64 | Transfer timestamp, valid with mv_ack |

## Verification
Two events can arrive in the same clock cycle: the acknowledge that returns a non-owned word 0, and a poll_demand pulse. The bench memory model is armed to raise poll_demand exactly on that acknowledge. It then counts word 0 reads of the address. Two reads before the engine finally suspends show that the pulse was honoured, while a single read shows it was lost. All buffer requests and write-backs are compared in order against a queue predicted from the descriptor contents.

// File: rtl/tdw_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the transmit descriptor walker.
package tdw_pkg;
    localparam int WORD_W      = 32;
    localparam int CNT_W       = 13;
    localparam int STAT_W      = 16;
    localparam int TS_W        = 64;
    localparam int DESC_BYTES  = 32;
    localparam int FETCH_WORDS = 4;
    localparam int TS_LO_WORD  = 6;
    localparam int TS_HI_WORD  = 7;
    localparam int CNT2_LSB    = 16;
    localparam int B_OWN       = 31;
    localparam int B_IRQ       = 30;
    localparam int B_LAST      = 29;
    localparam int B_EOR       = 21;
    localparam int B_CHAIN     = 20;

    typedef struct packed {
        logic              irq_req;
        logic              last;
        logic              eor;
        logic              chain;
        logic [CNT_W-1:0]  cnt1;
        logic [CNT_W-1:0]  cnt2;
        logic [WORD_W-1:0] addr1;
        logic [WORD_W-1:0] addr2;
    } desc_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_BUF, S_WB, S_NEXT, S_SUSP
    } state_t;
endpackage

// File: rtl/tdw_desc_store.sv
`timescale 1ns/1ps
// Holds the control words of the current descriptor.
// Assumes one word is loaded per acknowledged read, selected by idx.
module tdw_desc_store #(
    parameter int WORDS = 4,
    parameter int W     = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [IW-1:0]           idx,
    input  logic [W-1:0]            din,
    output logic [WORDS-1:0][W-1:0] words
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Capture word g when it is the one being read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (load && idx == IW'(g))
                words[g] <= din;
        end
    end
endmodule

// File: rtl/tdw_desc_decode.sv
`timescale 1ns/1ps
// Splits fetched control words into fields and builds the word 0 write-back value.
// Assumes words[0..3] hold control, counts, address 1, address 2 / link.
module tdw_desc_decode
    import tdw_pkg::*;
(
    input  logic [FETCH_WORDS-1:0][WORD_W-1:0] words,
    input  logic [STAT_W-1:0]                  stat_acc,
    output desc_t                              d,
    output logic [WORD_W-1:0]                  wb_word
);
    logic unused_bits;

    // Field extraction.
    always_comb begin
        d.irq_req = words[0][B_IRQ];
        d.last    = words[0][B_LAST];
        d.eor     = words[0][B_EOR];
        d.chain   = words[0][B_CHAIN];
        d.cnt1    = words[1][CNT_W-1:0];
        d.cnt2    = words[1][CNT2_LSB +: CNT_W];
        d.addr1   = words[2];
        d.addr2   = words[3];
    end

    // Ownership cleared, control bits kept, status bits replaced.
    assign wb_word = {1'b0, words[0][WORD_W-2:STAT_W], stat_acc};

    assign unused_bits = ^{words[0][B_OWN], words[0][STAT_W-1:0],
                           words[1][WORD_W-1:CNT2_LSB+CNT_W],
                           words[1][CNT2_LSB-1:CNT_W]};
endmodule

// File: rtl/tdw_next_addr.sv
`timescale 1ns/1ps
// Chooses the following descriptor address: base on end of ring, link in chain
// mode, otherwise the next slot. End of ring wins over chain.
module tdw_next_addr
    import tdw_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] link,
    input  logic              eor,
    input  logic              chain,
    output logic [WORD_W-1:0] nxt
);
    // Priority select of the successor.
    always_comb begin
        if (eor)
            nxt = base;
        else if (chain)
            nxt = link;
        else
            nxt = cur + WORD_W'(DESC_BYTES);
    end
endmodule

// File: rtl/tx_desc_walker.sv
`timescale 1ns/1ps
// Transmit descriptor walker: fetch, ownership check, buffer issue,
// write-back and advance. Assumes acknowledges are one-cycle pulses that
// answer the request held at that moment.
module tx_desc_walker
    import tdw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WORD_W-1:0]   base_addr,
    input  logic                poll_demand,
    output logic                suspended,
    output logic                irq,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                mv_req,
    output logic [WORD_W-1:0]   mv_addr,
    output logic [CNT_W-1:0]    mv_len,
    input  logic                mv_ack,
    input  logic [STAT_W-1:0]   mv_stat,
    input  logic [TS_W-1:0]     mv_ts
);
    localparam int RIW = $clog2(FETCH_WORDS);
    localparam logic [RIW-1:0] RD_LAST = RIW'(FETCH_WORDS - 1);
    localparam logic [WORD_W-1:0] OFF_TSL = WORD_W'(TS_LO_WORD * 4);
    localparam logic [WORD_W-1:0] OFF_TSH = WORD_W'(TS_HI_WORD * 4);

    state_t                          state;
    logic [RIW-1:0]                  rd_idx;
    logic                            buf_idx;
    logic [1:0]                      wb_idx;
    logic [WORD_W-1:0]               cur_addr;
    logic [WORD_W-1:0]               base_q;
    logic [STAT_W-1:0]               stat_acc;
    logic [TS_W-1:0]                 ts_q;
    logic                            irq_q;
    logic [FETCH_WORDS-1:0][WORD_W-1:0] words;
    desc_t                           d;
    logic [WORD_W-1:0]               wb_word;
    logic [WORD_W-1:0]               next_addr;
    logic                            buf_use;
    logic                            fetch_load;

    assign fetch_load = (state == S_FETCH) && mem_ack;

    tdw_desc_store #(.WORDS(FETCH_WORDS), .W(WORD_W)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fetch_load),
        .idx   (rd_idx),
        .din   (mem_rdata),
        .words (words)
    );

    tdw_desc_decode i_decode (
        .words    (words),
        .stat_acc (stat_acc),
        .d        (d),
        .wb_word  (wb_word)
    );

    tdw_next_addr i_next (
        .cur   (cur_addr),
        .base  (base_q),
        .link  (d.addr2),
        .eor   (d.eor),
        .chain (d.chain),
        .nxt   (next_addr)
    );

    // Whether the current buffer slot carries data to issue.
    always_comb begin
        if (buf_idx)
            buf_use = !d.chain && (d.cnt2 != '0);
        else
            buf_use = (d.cnt1 != '0);
    end

    // Mover request from the current buffer slot.
    always_comb begin
        mv_req  = (state == S_BUF) && buf_use;
        mv_addr = buf_idx ? d.addr2 : d.addr1;
        mv_len  = buf_idx ? d.cnt2  : d.cnt1;
    end

    // Memory request: word reads during fetch, three writes during write-back.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_addr;
        mem_wdata = '0;
        case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + (WORD_W'(rd_idx) << 2);
            end
            S_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                case (wb_idx)
                    2'd0: begin
                        mem_addr  = cur_addr + OFF_TSL;
                        mem_wdata = ts_q[WORD_W-1:0];
                    end
                    2'd1: begin
                        mem_addr  = cur_addr + OFF_TSH;
                        mem_wdata = ts_q[TS_W-1:WORD_W];
                    end
                    default: begin
                        mem_addr  = cur_addr;
                        mem_wdata = wb_word;
                    end
                endcase
            end
            default: ;
        endcase
    end

    assign suspended = (state == S_SUSP);
    assign irq       = irq_q;

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            rd_idx   <= '0;
            buf_idx  <= 1'b0;
            wb_idx   <= '0;
            cur_addr <= '0;
            base_q   <= '0;
            stat_acc <= '0;
            ts_q     <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        base_q   <= base_addr;
                        cur_addr <= base_addr;
                        rd_idx   <= '0;
                        state    <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        if (rd_idx == '0 && !mem_rdata[B_OWN]) begin
                            state <= poll_demand ? S_FETCH : S_SUSP;
                        end else if (rd_idx == RD_LAST) begin
                            rd_idx   <= '0;
                            buf_idx  <= 1'b0;
                            stat_acc <= '0;
                            ts_q     <= '0;
                            state    <= S_BUF;
                        end else begin
                            rd_idx <= rd_idx + 1'b1;
                        end
                    end
                end
                S_BUF: begin
                    if (!buf_use || mv_ack) begin
                        if (buf_use) begin
                            stat_acc <= stat_acc | mv_stat;
                            ts_q     <= mv_ts;
                        end
                        if (buf_idx) begin
                            wb_idx <= '0;
                            state  <= S_WB;
                        end else begin
                            buf_idx <= 1'b1;
                        end
                    end
                end
                S_WB: begin
                    if (mem_ack) begin
                        if (wb_idx == 2'd2) begin
                            irq_q <= d.last && d.irq_req;
                            state <= S_NEXT;
                        end else begin
                            wb_idx <= wb_idx + 1'b1;
                        end
                    end
                end
                S_NEXT: begin
                    cur_addr <= next_addr;
                    rd_idx   <= '0;
                    state    <= S_FETCH;
                end
                S_SUSP: begin
                    if (poll_demand) begin
                        rd_idx <= '0;
                        state  <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
    AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req && !mv_ack |=> mv_req && $stable(mv_addr) && $stable(mv_len)); // R10
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !mem_req && !mv_req); // R3
    AST_SUSP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && poll_demand |=> !suspended && mem_req && !mem_we && mem_addr == $past(mem_addr)); // R3
    AST_MV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> mv_len != '0); // R4
endmodule

// File: tb/test_tx_desc_walker.sv
`timescale 1ns/1ps
// Scoreboard bench: descriptor setup pushes predicted mover requests and
// write-backs; a serving loop answers the ports and compares in order.
module test_tx_desc_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic        poll_t = 1'b0;
    logic        poll_co = 1'b0;
    logic        poll_demand;
    logic        suspended, irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mv_req;
    logic [31:0] mv_addr;
    logic [12:0] mv_len;
    logic        mv_ack = 1'b0;
    logic [15:0] mv_stat = '0;
    logic [63:0] mv_ts = '0;

    assign poll_demand = poll_t | poll_co;

    always #2.5 clk = ~clk;

    tx_desc_walker i_tx_desc_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .poll_demand(poll_demand), .suspended(suspended), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_ack(mv_ack),
        .mv_stat(mv_stat), .mv_ts(mv_ts)
    );

    typedef struct {
        bit          is_wr;
        logic [31:0] a;
        logic [31:0] v;
    } item_t;

    item_t       sb[$];
    logic [31:0] mem [0:255];
    int          n_chk = 0;
    int          n_bad = 0;
    int          rd0_cnt = 0;
    logic [31:0] last_rd0 = '0;
    int          irq_cnt = 0;
    bit          coinc_arm = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: place a descriptor and predict its traffic (R4, R5, R7).
    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        logic [12:0] l1;
        logic [12:0] l2;
        logic [15:0] acc;
        logic [63:0] ts;
        logic [7:0]  ix;
        l1 = w1[12:0];
        l2 = w1[28:16];
        acc = '0;
        ts = '0;
        ix = a[9:2];
        mem[ix] = w0;
        mem[ix + 8'd1] = w1;
        mem[ix + 8'd2] = w2;
        mem[ix + 8'd3] = w3;
        if (l1 != 0) begin
            sb.push_back('{1'b0, w2, {19'b0, l1}});
            acc = acc | {3'b0, l1};
            ts = {19'b0, l1, w2};
        end
        if (!w0[20] && l2 != 0) begin
            sb.push_back('{1'b0, w3, {19'b0, l2}});
            acc = acc | {3'b0, l2};
            ts = {19'b0, l2, w3};
        end
        sb.push_back('{1'b1, a + 32'd24, ts[31:0]});
        sb.push_back('{1'b1, a + 32'd28, ts[63:32]});
        sb.push_back('{1'b1, a, {1'b0, w0[30:16], acc}});
    endtask

    // Monitor and responder for memory and mover ports.
    task automatic serve();
        item_t it;
        forever begin
            @(negedge clk);
            poll_co = 1'b0;
            if (irq) irq_cnt++;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req && rst_n) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[9:2]] = mem_wdata;
                    if (sb.size() == 0) begin
                        check(1'b0, "R7 unexpected write", {32'b0, mem_addr}, 64'h0);
                    end else begin
                        it = sb.pop_front();
                        check(it.is_wr && it.a == mem_addr && it.v == mem_wdata, "R7 write-back",
                              {mem_addr, mem_wdata}, {it.a, it.v});
                    end
                end else begin
                    mem_rdata = mem[mem_addr[9:2]];
                    if (mem_addr[4:0] == 5'd0) begin
                        rd0_cnt++;
                        last_rd0 = mem_addr;
                        if (coinc_arm && !mem_rdata[31]) begin
                            poll_co = 1'b1;
                            coinc_arm = 1'b0;
                        end
                    end
                end
            end
            if (mv_ack) begin
                mv_ack = 1'b0;
            end else if (mv_req && rst_n) begin
                mv_ack = 1'b1;
                mv_stat = {3'b0, mv_len};
                mv_ts = {19'b0, mv_len, mv_addr};
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected buffer", {32'b0, mv_addr}, 64'h0);
                end else begin
                    it = sb.pop_front();
                    check(!it.is_wr && it.a == mv_addr && it.v == {19'b0, mv_len}, "R4 buffer issue",
                          {mv_addr, 19'b0, mv_len}, {it.a, it.v});
                end
            end
        end
    endtask

    task automatic pulse_poll();
        @(negedge clk);
        poll_t = 1'b1;
        @(negedge clk);
        poll_t = 1'b0;
    endtask

    task automatic wait_susp(input string tag);
        int n;
        n = 0;
        @(negedge clk);
        while (!suspended && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(suspended, tag, {63'b0, suspended}, 64'h1);
    endtask

    task automatic run_all();
        int rd_before;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!mem_req, "R1 mem_req", {63'b0, mem_req}, 64'h0);
        check(!mv_req, "R1 mv_req", {63'b0, mv_req}, 64'h0);
        check(!suspended, "R1 suspended", {63'b0, suspended}, 64'h0);
        check(!irq, "R1 irq", {63'b0, irq}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!mem_req, "R1 idle without start", {63'b0, mem_req}, 64'h0);

        // Ring of descriptors: R2, R4, R5, R6, R7, R8
        put_desc(32'h100, 32'h9000_0000, (32'd200 << 16) | 32'd100, 32'h1000, 32'h2000);
        put_desc(32'h120, 32'h8000_0000, (32'd64 << 16), 32'h1100, 32'h2100);
        put_desc(32'h140, 32'hE010_0000, (32'd77 << 16) | 32'd50, 32'h1200, 32'h0000_0200);
        put_desc(32'h200, 32'h8030_0000, 32'd10, 32'h1300, 32'h0000_0300);
        @(negedge clk);
        base_addr = 32'h100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_addr = 32'h0;
        wait_susp("R3 suspend on wrapped non-owned descriptor");
        check(rd0_cnt == 5, "R2 R5 R6 word0 read count", 64'(rd0_cnt), 64'd5);
        check(last_rd0 == 32'h100, "R6 end of ring returns to base", {32'b0, last_rd0}, 64'h100);
        check(irq_cnt == 1, "R8 irq only for last+request", 64'(irq_cnt), 64'd1);
        check(sb.size() == 0, "R4 all predicted items seen", 64'(sb.size()), 64'd0);

        // R3: poll while still not owned
        rd_before = rd0_cnt;
        pulse_poll();
        wait_susp("R3 suspend again after poll");
        check(rd0_cnt == rd_before + 1, "R3 one refetch per poll", 64'(rd0_cnt), 64'(rd_before + 1));
        check(last_rd0 == 32'h100, "R3 refetch same address", {32'b0, last_rd0}, 64'h100);

        // R7: re-armed descriptor with no data, R8 irq
        put_desc(32'h100, 32'hE000_0000, 32'd0, 32'h1400, 32'h2400);
        pulse_poll();
        wait_susp("R3 suspend at next slot");
        check(irq_cnt == 2, "R8 irq after empty last descriptor", 64'(irq_cnt), 64'd2);
        check(last_rd0 == 32'h120, "R6 next slot is +32", {32'b0, last_rd0}, 64'h120);
        check(sb.size() == 0, "R7 empty descriptor write-back seen", 64'(sb.size()), 64'd0);

        // R9: poll coinciding with the non-owned word 0 acknowledge
        rd_before = rd0_cnt;
        coinc_arm = 1'b1;
        pulse_poll();
        wait_susp("R9 final suspend");
        check(rd0_cnt == rd_before + 2, "R9 coincident poll honoured", 64'(rd0_cnt), 64'(rd_before + 2));
        check(last_rd0 == 32'h120, "R9 same address", {32'b0, last_rd0}, 64'h120);
        check(!mv_req && !mem_req, "R3 quiet while suspended", {62'b0, mv_req, mem_req}, 64'h0);
    endtask

    initial begin
        fork
            serve();
        join_none
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired R1 actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule